// File: doc/BRIEF.md
# Sensor Measurement Register Slave

This block is a memory-mapped slave on an AXI4-Lite bus. It sits between a processor and a humidity/temperature sensor controller and shows the controller's results as two read-only 32-bit words. One word holds the most recent measurement. The other holds the error and busy flags. The block needs no processor involvement to run the sensor. After reset is released it counts one measurement period, which is a parameter in clock cycles. It then pulses the controller's start input. From then on, every period it captures the finished measurement and starts a new one.

The controller returns a 40-bit frame. The upper 32 bits are four data bytes, and the lowest byte is a checksum that the controller has already verified. Bits 39:24 of the frame are humidity and bits 23:8 are temperature. Both are copied most significant bit first into the measurement word.

The write path and the read path are separate state machines. A write can never change anything, so every write is answered with an error response chosen by its address. A read returns the addressed word, or a decode error when the address is outside the two mapped words.

Top module: `sensor_axil_regs`

## Requirements
- R1: Out of reset, the measurement word (byte offset 0x0) reads 0xFFFFFFFF and the flag word (byte offset 0x4) reads 0x00000000.
- R2: `sns_start` is a one-cycle pulse. The first pulse rises PERIOD_CYC clock edges after reset is released, and each later pulse rises exactly PERIOD_CYC cycles after the one before.
- R3: The first start pulse captures nothing. At every later start pulse the block samples `sns_result[39:8]` into the measurement word, with humidity in bits 31:16 and temperature in bits 15:0. At the same time it samples `sns_proto_err` into flag-word bit 2 and `sns_sum_err` into flag-word bit 0. The new values can be read from the next cycle on.
- R4: Flag-word bit 1 follows `sns_busy`, which is sampled on every clock edge. Flag-word bits 31:3 always read 0.
- R5: A read of byte addresses 0x0–0x3 returns the measurement word with RRESP 2'b00. A read of 0x4–0x7 returns the flag word with RRESP 2'b00. Any other address returns RRESP 2'b11 with RDATA equal to 0.
- R6: A write to byte addresses 0x0–0x7 is answered with BRESP 2'b10. A write to any other address is answered with BRESP 2'b11. No write changes either word.
- R7: AWREADY and WREADY rise together, in the same cycle, and only while both AWVALID and WVALID are high. BVALID then stays high with a stable BRESP until BREADY is seen, and no new write is accepted in the meantime.
- R8: When idle, the read path holds ARREADY high. An accepted address produces RVALID, and RVALID stays high with stable RDATA and RRESP until RREADY is seen. ARREADY stays low while a response is pending.
- R9: A read and a write presented in the same cycle are both served independently. Each gets the response it would get on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | 32 | Write data (discarded) |
| s_wstrb | input | 4 | Write byte strobes (discarded) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| sns_start | output | 1 | Start-measurement pulse to the sensor controller |
| sns_result | input | 40 | Last frame from the controller, checksum byte in bits 7:0 |
| sns_busy | input | 1 | Controller busy flag |
| sns_proto_err | input | 1 | Controller protocol-error flag |
| sns_sum_err | input | 1 | Controller checksum-error flag |

## Verification
The bench drives two different result frames with opposite flag settings. Because the frames differ, a missed capture, a capture one period late, or a capture taken on the very first start pulse gives a different readback. Swapped humidity and temperature halves also give a different readback, as does a crossed flag bit. Reads use offsets inside each word (0x3, 0x7) and outside the map (0x8 and a high address). Writes use mapped and unmapped addresses, and one write presents its data several cycles after its address. This separates an address-dependent error code from a fixed one, and it shows whether the block waits for both valids before accepting. A read and a write are also issued in the same cycle, to show that the two paths do not block each other.

// File: rtl/sensor_axil_pkg.sv
package sensor_axil_pkg;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_EXOKAY = 2'b01,
      RESP_SLVERR = 2'b10,
      RESP_DECERR = 2'b11
   } axi_resp_e;

   localparam int REG_W    = 32;
   localparam int CSUM_W   = 8;
   localparam int FRAME_W  = REG_W + CSUM_W;

   // flag-word bit positions
   localparam int FLG_SUM   = 0;
   localparam int FLG_BUSY  = 1;
   localparam int FLG_PROTO = 2;

   // word indices inside the slave window
   localparam int WORD_MEAS = 0;
   localparam int WORD_FLAG = 1;
   localparam int WORD_CNT  = 2;

endpackage

// File: rtl/sensor_tick_gen.sv
module sensor_tick_gen #(
   parameter int unsigned PERIOD_CYC = 200_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic start_o,
   output logic capture_o
);
   localparam int CNT_W = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             wrap;

   assign wrap = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         armed_q   <= 1'b0;
         start_o   <= 1'b0;
         capture_o <= 1'b0;
      end else begin
         start_o   <= wrap;
         capture_o <= wrap & armed_q;
         if (wrap) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sensor_result_regs.sv
module sensor_result_regs
   import sensor_axil_pkg::*;
#(
   parameter int RES_W = FRAME_W,
   parameter int OUT_W = REG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic [RES_W-1:0] result_i,
   input  logic             proto_i,
   input  logic             sum_i,
   input  logic             busy_i,
   output logic [OUT_W-1:0] meas_o,
   output logic [OUT_W-1:0] flag_o
);
   localparam int DROP = RES_W - OUT_W;

   logic [OUT_W-1:0] meas_q;
   logic             proto_q, sum_q, busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meas_q  <= '1;
         proto_q <= 1'b0;
         sum_q   <= 1'b0;
      end else if (capture_i) begin
         meas_q  <= result_i[RES_W-1:DROP];
         proto_q <= proto_i;
         sum_q   <= sum_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy_i;
   end

   // build the flag word bit by bit: only three positions carry state
   for (genvar b = 0; b < OUT_W; b++) begin : g_flag
      if (b == FLG_SUM) begin : g_sum
         assign flag_o[b] = sum_q;
      end else if (b == FLG_BUSY) begin : g_busy
         assign flag_o[b] = busy_q;
      end else if (b == FLG_PROTO) begin : g_proto
         assign flag_o[b] = proto_q;
      end else begin : g_zero
         assign flag_o[b] = 1'b0;
      end
   end

   assign meas_o = meas_q;

   logic unused_low;
   assign unused_low = ^result_i[DROP-1:0];
endmodule

// File: rtl/axil_wr_channel.sv
module axil_wr_channel
   import sensor_axil_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              awvalid,
   output logic              awready,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              wvalid,
   output logic              wready,
   output logic              bvalid,
   input  logic              bready,
   output logic [1:0]        bresp
);
   localparam int WA_W = ADDR_W - 2;

   typedef enum logic {WR_IDLE, WR_RESP} wr_state_e;

   wr_state_e        st_q;
   logic [WA_W-1:0]  waddr_q;
   logic             take;

   assign take    = (st_q == WR_IDLE) && awvalid && wvalid;
   assign awready = take;
   assign wready  = take;
   assign bvalid  = (st_q == WR_RESP);
   assign bresp   = (waddr_q < WA_W'(WORD_CNT)) ? RESP_SLVERR : RESP_DECERR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= WR_IDLE;
         waddr_q <= '0;
      end else begin
         case (st_q)
            WR_IDLE: if (take) begin
               waddr_q <= awaddr[ADDR_W-1:2];
               st_q    <= WR_RESP;
            end
            WR_RESP: if (bready) st_q <= WR_IDLE;
            default: st_q <= WR_IDLE;
         endcase
      end
   end

   logic unused_lsb;
   assign unused_lsb = ^awaddr[1:0];
endmodule

// File: rtl/axil_rd_channel.sv
module axil_rd_channel
   import sensor_axil_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arvalid,
   output logic              arready,
   input  logic [ADDR_W-1:0] araddr,
   output logic              rvalid,
   input  logic              rready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   input  logic [DATA_W-1:0] meas_i,
   input  logic [DATA_W-1:0] flag_i
);
   localparam int WA_W = ADDR_W - 2;

   typedef enum logic [1:0] {RD_IDLE, RD_LOAD, RD_RESP} rd_state_e;

   rd_state_e         st_q;
   logic [WA_W-1:0]   raddr_q;
   logic [DATA_W-1:0] rdata_q;
   logic [1:0]        rresp_q;

   assign arready = (st_q == RD_IDLE);
   assign rvalid  = (st_q == RD_RESP);
   assign rdata   = rdata_q;
   assign rresp   = rresp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RD_IDLE;
         raddr_q <= '0;
         rdata_q <= '0;
         rresp_q <= RESP_OKAY;
      end else begin
         case (st_q)
            RD_IDLE: if (arvalid) begin
               raddr_q <= araddr[ADDR_W-1:2];
               st_q    <= RD_LOAD;
            end
            RD_LOAD: begin
               if (raddr_q == WA_W'(WORD_MEAS)) begin
                  rdata_q <= meas_i;
                  rresp_q <= RESP_OKAY;
               end else if (raddr_q == WA_W'(WORD_FLAG)) begin
                  rdata_q <= flag_i;
                  rresp_q <= RESP_OKAY;
               end else begin
                  rdata_q <= '0;
                  rresp_q <= RESP_DECERR;
               end
               st_q <= RD_RESP;
            end
            RD_RESP: if (rready) st_q <= RD_IDLE;
            default: st_q <= RD_IDLE;
         endcase
      end
   end

   logic unused_lsb;
   assign unused_lsb = ^araddr[1:0];
endmodule

// File: rtl/sensor_axil_regs.sv
module sensor_axil_regs
   import sensor_axil_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int unsigned PERIOD_CYC = 200_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [ADDR_W-1:0] s_awaddr,
   input  logic              s_wvalid,
   output logic              s_wready,
   input  logic [31:0]       s_wdata,
   input  logic [3:0]        s_wstrb,
   output logic              s_bvalid,
   input  logic              s_bready,
   output logic [1:0]        s_bresp,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic              sns_start,
   input  logic [39:0]       sns_result,
   input  logic              sns_busy,
   input  logic              sns_proto_err,
   input  logic              sns_sum_err
);
   // elaboration-time parameter checks
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must be at least 4");
   end
   if (PERIOD_CYC < 2) begin : g_bad_period
      $error("PERIOD_CYC must be at least 2");
   end
   if (FRAME_W != 40 || REG_W != 32) begin : g_bad_frame
      $error("frame and register widths do not match the port list");
   end

   logic             capture;
   logic [REG_W-1:0] meas_w, flag_w;

   sensor_tick_gen #(.PERIOD_CYC(PERIOD_CYC)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_o   (sns_start),
      .capture_o (capture)
   );

   sensor_result_regs #(.RES_W(FRAME_W), .OUT_W(REG_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .result_i  (sns_result),
      .proto_i   (sns_proto_err),
      .sum_i     (sns_sum_err),
      .busy_i    (sns_busy),
      .meas_o    (meas_w),
      .flag_o    (flag_w)
   );

   axil_wr_channel #(.ADDR_W(ADDR_W)) u_wr (
      .clk     (clk),
      .rst_n   (rst_n),
      .awvalid (s_awvalid),
      .awready (s_awready),
      .awaddr  (s_awaddr),
      .wvalid  (s_wvalid),
      .wready  (s_wready),
      .bvalid  (s_bvalid),
      .bready  (s_bready),
      .bresp   (s_bresp)
   );

   axil_rd_channel #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .arvalid (s_arvalid),
      .arready (s_arready),
      .araddr  (s_araddr),
      .rvalid  (s_rvalid),
      .rready  (s_rready),
      .rdata   (s_rdata),
      .rresp   (s_rresp),
      .meas_i  (meas_w),
      .flag_i  (flag_w)
   );

   logic unused_wr;
   assign unused_wr = ^{s_wdata, s_wstrb};
endmodule

// File: rtl/sensor_axil_chk.sv
module sensor_axil_chk #(
   parameter int unsigned PERIOD_CYC = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        s_awvalid,
   input logic        s_awready,
   input logic        s_wvalid,
   input logic        s_wready,
   input logic        s_bvalid,
   input logic        s_bready,
   input logic [1:0]  s_bresp,
   input logic        s_arready,
   input logic        s_rvalid,
   input logic        s_rready,
   input logic [31:0] s_rdata,
   input logic [1:0]  s_rresp,
   input logic        sns_start
);
   // cycles since the last start pulse (or since reset)
   int unsigned gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         gap_q <= 0;
      else if (sns_start) gap_q <= 1;
      else                gap_q <= gap_q + 1;
   end

   p_start_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sns_start |-> (gap_q == PERIOD_CYC));

   p_start_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sns_start |=> !sns_start);

   p_both_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awready || s_wready) |-> (s_awvalid && s_wvalid && s_awready && s_wready));

   p_bresp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bresp)));

   p_no_accept_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> !s_awready);

   p_bresp_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> s_bresp[1]);

   p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));

   p_ar_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid |-> !s_arready);

   p_decerr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && s_rresp == 2'b11) |-> (s_rdata == 32'h0));

   p_rresp_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid |-> (s_rresp == 2'b00 || s_rresp == 2'b11));
endmodule

bind sensor_axil_regs sensor_axil_chk #(.PERIOD_CYC(PERIOD_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_awvalid (s_awvalid),
   .s_awready (s_awready),
   .s_wvalid  (s_wvalid),
   .s_wready  (s_wready),
   .s_bvalid  (s_bvalid),
   .s_bready  (s_bready),
   .s_bresp   (s_bresp),
   .s_arready (s_arready),
   .s_rvalid  (s_rvalid),
   .s_rready  (s_rready),
   .s_rdata   (s_rdata),
   .s_rresp   (s_rresp),
   .sns_start (sns_start)
);

// File: tb/sensor_axil_regs_test.sv
`timescale 1ns/1ps
module sensor_axil_regs_test;
   localparam int AW = 32;
   localparam int P  = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_awvalid = 0, s_wvalid = 0, s_bready = 0;
   logic          s_arvalid = 0, s_rready = 0;
   logic [AW-1:0] s_awaddr = '0, s_araddr = '0;
   logic [31:0]   s_wdata = '0;
   logic [3:0]    s_wstrb = '0;
   logic          s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   logic [1:0]    s_bresp, s_rresp;
   logic [31:0]   s_rdata;
   logic          sns_start;
   logic [39:0]   sns_result = '0;
   logic          sns_busy = 0, sns_proto_err = 0, sns_sum_err = 0;

   sensor_axil_regs #(.ADDR_W(AW), .PERIOD_CYC(P)) uut (.*);

   always #2.5 clk = ~clk;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          edges;
   bit          exp_start, cap_pend;
   logic [31:0] exp_meas;
   bit          exp_pe, exp_ce, exp_busy;

   function automatic logic [31:0] exp_flag();
      return {29'b0, exp_pe, exp_busy, exp_ce};
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edges = 0; exp_start = 0; cap_pend = 0;
         exp_meas = 32'hFFFF_FFFF; exp_pe = 0; exp_ce = 0; exp_busy = 0;
      end else begin
         edges++;
         if (cap_pend) begin
            exp_meas = sns_result[39:8];
            exp_pe   = sns_proto_err;
            exp_ce   = sns_sum_err;
         end
         exp_busy  = sns_busy;
         exp_start = (edges % P == 0);
         cap_pend  = (edges % P == 0) && (edges >= 2 * P);
      end
   end

   // start pulse compared on every clock (R2)
   always @(negedge clk) begin
      if (!done) chk("R2 start pulse", {31'b0, sns_start}, {31'b0, exp_start});
   end

   // ---------------- bus tasks ----------------
   task automatic wait_safe();
      while ((edges % P) < 4 || (edges % P) > P - 12) @(negedge clk);
   endtask

   task automatic wait_edges(input int n);
      while (edges < n) @(negedge clk);
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d, output logic [1:0] r);
      @(negedge clk);
      chk("R8 arready idle", {31'b0, s_arready}, 32'd1);
      s_arvalid = 1; s_araddr = a;
      @(negedge clk);
      s_arvalid = 0;
      while (!s_rvalid) @(negedge clk);
      d = s_rdata; r = s_rresp;
      chk("R8 arready low while pending", {31'b0, s_arready}, 32'd0);
      @(negedge clk);
      chk("R8 rdata held", s_rdata, d);
      chk("R8 rvalid held", {31'b0, s_rvalid}, 32'd1);
      s_rready = 1;
      @(negedge clk);
      s_rready = 0;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input int wdelay, output logic [1:0] r);
      @(negedge clk);
      s_awvalid = 1; s_awaddr = a; s_wdata = 32'hDEAD_BEEF; s_wstrb = 4'hF;
      for (int i = 0; i < wdelay; i++) begin
         chk("R7 awready waits for wvalid", {30'b0, s_awready, s_wready}, 32'd0);
         @(negedge clk);
      end
      s_wvalid = 1;
      #0.1;
      chk("R7 joint accept", {30'b0, s_awready, s_wready}, 32'd3);
      @(negedge clk);
      s_awvalid = 0; s_wvalid = 0;
      while (!s_bvalid) @(negedge clk);
      r = s_bresp;
      @(negedge clk);
      chk("R7 bvalid held", {31'b0, s_bvalid}, 32'd1);
      chk("R7 bresp held", {30'b0, s_bresp}, {30'b0, r});
      s_bready = 1;
      @(negedge clk);
      s_bready = 0;
   endtask

   // ---------------- stimulus ----------------
   logic [31:0] d;
   logic [1:0]  rr, wr;

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;

      // reset state
      wait_safe();
      chk("R2 start low out of reset", {31'b0, sns_start}, 32'd0);
      do_read(32'h0, d, rr);
      chk("R1 meas reset", d, 32'hFFFF_FFFF);
      chk("R1 meas resp", {30'b0, rr}, 32'd0);
      do_read(32'h4, d, rr);
      chk("R1 flag reset", d, 32'h0);

      // first frame presented before the first start
      sns_result = 40'hA55A_3CC3_77; sns_proto_err = 1; sns_sum_err = 0; sns_busy = 1;
      wait_edges(P + 4); wait_safe();
      do_read(32'h0, d, rr);
      chk("R3 first start captures nothing", d, 32'hFFFF_FFFF);
      do_read(32'h4, d, rr);
      chk("R4 busy live, flags not yet captured", d, 32'h2);

      wait_edges(2 * P + 4); wait_safe();
      do_read(32'h0, d, rr);
      chk("R3 capture frame A", d, 32'hA55A_3CC3);
      chk("R3 humidity half", {16'b0, d[31:16]}, 32'h0000_A55A);
      chk("R3 model meas", d, exp_meas);
      do_read(32'h4, d, rr);
      chk("R3 flags A", d, 32'h6);
      chk("R4 model flags", d, exp_flag());

      // second frame, opposite flags
      sns_result = 40'h1234_5678_9A; sns_proto_err = 0; sns_sum_err = 1; sns_busy = 0;
      wait_edges(3 * P + 4); wait_safe();
      do_read(32'h0, d, rr);
      chk("R3 capture frame B", d, 32'h1234_5678);
      do_read(32'h4, d, rr);
      chk("R4 flags B busy cleared", d, 32'h1);
      chk("R4 model flags B", d, exp_flag());

      // address decode for reads
      wait_safe(); do_read(32'h3, d, rr);
      chk("R5 offset 3 data", d, 32'h1234_5678);
      chk("R5 offset 3 okay", {30'b0, rr}, 32'd0);
      wait_safe(); do_read(32'h7, d, rr);
      chk("R5 offset 7 flags", d, 32'h1);
      chk("R5 offset 7 okay", {30'b0, rr}, 32'd0);
      wait_safe(); do_read(32'h8, d, rr);
      chk("R5 0x8 decerr", {30'b0, rr}, 32'd3);
      chk("R5 0x8 zero data", d, 32'h0);
      wait_safe(); do_read(32'hFFFF_FFFC, d, rr);
      chk("R5 high decerr", {30'b0, rr}, 32'd3);

      // writes
      do_write(32'h0, 0, wr);
      chk("R6 write meas slverr", {30'b0, wr}, 32'd2);
      do_write(32'h4, 3, wr);
      chk("R6 write flag slverr", {30'b0, wr}, 32'd2);
      do_write(32'h8, 0, wr);
      chk("R6 write 0x8 decerr", {30'b0, wr}, 32'd3);
      do_write(32'h400, 1, wr);
      chk("R6 write high decerr", {30'b0, wr}, 32'd3);
      wait_safe(); do_read(32'h0, d, rr);
      chk("R6 meas unchanged after writes", d, 32'h1234_5678);
      wait_safe(); do_read(32'h4, d, rr);
      chk("R6 flags unchanged after writes", d, 32'h1);

      // concurrent read and write
      sns_busy = 1;
      repeat (2) @(negedge clk);
      wait_safe();
      fork
         do_write(32'h4, 0, wr);
         do_read(32'h4, d, rr);
      join
      chk("R9 concurrent write resp", {30'b0, wr}, 32'd2);
      chk("R9 concurrent read data", d, 32'h3);
      chk("R9 concurrent read resp", {30'b0, rr}, 32'd0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule